// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits at the issue stage of an in-order core that has two integer pipes, U and V. In every cycle it receives two decoded instruction descriptors, the older one first. It decides whether the older instruction goes to U alone, or whether the two go together with the older one in U and the younger one in V. To reach that decision it sorts each instruction into one of four pairing categories: either pipe, U only, V only, or not pairable. It then checks a register dependency between the pair, which push, pop and call sequences are exempt from. Finally it applies a memory-ordering hold. That hold applies when the older instruction both reads and writes memory and the younger one loads.

The decision is registered. The issue flags and the consumed count appear one clock after the descriptors are sampled, so the front end can advance its queue by that count. A downstream stall suppresses issue. While the memory-ordering hold is running, no new group is taken, and the V pipe's load waits until the older instruction reaches its last cycle.

Top module: `dual_issue_pairer`

## Requirements
- R1: A synchronous active-low reset clears issue_u, issue_v, consumed and v_hold to zero.
- R2: An instruction with the immediate-and-displacement flag set is not pairable in either slot, whatever its opcode.
- R3: Opcodes 0 to 5 (ALU, move, compare, test, address calculation, increment/decrement) are pairable in either pipe. So are push (6) and pop (7) whose memory kind is not 3 (read-modify-write). Two such instructions pair.
- R4: An either-pipe instruction that has any of the three prefix bits set (escape, operand size, repeat) becomes U-only. It still pairs as the older instruction, but it blocks pairing as the younger one.
- R5: Branch (8) is V-only. Call (9) is V-only when its constant-target flag is set, and not pairable otherwise.
- R6: Shift (10) with the constant-count flag set is U-only. Rotate (11) with the count-is-one flag set is U-only. Either one without its flag is not pairable.
- R7: A not-pairable instruction in either slot (including opcodes 12 to 15) forces single issue of the older instruction, with consumed equal to 1.
- R8: issue_v is never asserted without issue_u.
- R9: When the younger instruction's valid source register equals the older instruction's valid destination register, the pair is not issued.
- R10: A push or pop followed by a push, pop or call pairs even if the register match of R9 holds.
- R11: When a pair is issued with the older memory kind 3 and the younger memory kind 1 (load) or 3, v_hold is high for the 2 cycles after the issue. During that time nothing new is issued.
- R12: A high stall or a low old_vld gives no issue (consumed 0). A low yng_vld gives single issue.
- R13: The outputs reflect the inputs sampled at the previous rising clock edge. consumed is 0, 1 or 2 and matches the issue flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Downstream stall, suppresses issue |
| old_vld | input | 1 | Older descriptor is valid |
| old_op | input | 4 | Older opcode class |
| old_pfx | input | 3 | Older prefix bits (escape, operand size, repeat) |
| old_immdisp | input | 1 | Older carries immediate and displacement |
| old_mem | input | 2 | Older memory kind: 0 none, 1 load, 2 store, 3 read-modify-write |
| old_cnst | input | 1 | Older shift count or call target is constant |
| old_one | input | 1 | Older rotate count is exactly one |
| old_dst | input | REG_W | Older destination register |
| old_dst_vld | input | 1 | Older writes a register |
| yng_vld | input | 1 | Younger descriptor is valid |
| yng_op | input | 4 | Younger opcode class |
| yng_pfx | input | 3 | Younger prefix bits |
| yng_immdisp | input | 1 | Younger carries immediate and displacement |
| yng_mem | input | 2 | Younger memory kind |
| yng_cnst | input | 1 | Younger constant count or target |
| yng_one | input | 1 | Younger rotate count is one |
| yng_src | input | REG_W | Younger source register |
| yng_src_vld | input | 1 | Younger reads a register |
| issue_u | output | 1 | Older instruction issued to U |
| issue_v | output | 1 | Younger instruction issued to V |
| consumed | output | 2 | Descriptors consumed: 0, 1 or 2 |
| v_hold | output | 1 | V pipe load waits on the older instruction's store |

## Verification
Directed pairs cover each category in each slot. This tells apart a category that is wrong only in the older slot from one that is wrong only in the younger slot, for example a prefixed ALU operation that pairs when it is older but not when it is younger. Matched and unmatched register pairs are run with stack and non-stack opcodes, which separates the dependency block from its exemption. A read-modify-write followed by a load checks the length of the hold window, and stall and valid gaps check the suppression paths. Seeded random descriptors then mix all these fields, including back-to-back hold windows, against a bench-side model.

// File: rtl/pairing_pkg.sv
// Shared types for the dual-issue pairing checker.
// Assumes opcode, memory kind and category encodings are fixed as listed.
package pairing_pkg;

    typedef enum logic [1:0] {
        CAT_UV    = 2'd0,
        CAT_UONLY = 2'd1,
        CAT_VONLY = 2'd2,
        CAT_NONE  = 2'd3
    } pair_cat_e;

    typedef enum logic [3:0] {
        OP_ALU    = 4'd0,
        OP_MOV    = 4'd1,
        OP_CMP    = 4'd2,
        OP_TEST   = 4'd3,
        OP_ADDR   = 4'd4,
        OP_INCDEC = 4'd5,
        OP_PUSH   = 4'd6,
        OP_POP    = 4'd7,
        OP_BRANCH = 4'd8,
        OP_CALL   = 4'd9,
        OP_SHIFT  = 4'd10,
        OP_ROTATE = 4'd11,
        OP_MUL    = 4'd12,
        OP_DIV    = 4'd13,
        OP_FLOAT  = 4'd14,
        OP_OTHER  = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        MEM_NONE  = 2'd0,
        MEM_LOAD  = 2'd1,
        MEM_STORE = 2'd2,
        MEM_RMW   = 2'd3
    } mem_e;

    localparam int OP_W  = 4;
    localparam int PFX_W = 3;
    localparam int MEM_W = 2;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [PFX_W-1:0] pfx;
        logic             immdisp;
        logic [MEM_W-1:0] mem;
        logic             cnst;
        logic             one;
    } desc_t;

endpackage

// File: rtl/pair_classifier.sv
// Sorts one decoded descriptor into a pairing category.
// Assumes: purely combinational; the descriptor fields are already decoded.
module pair_classifier
    import pairing_pkg::*;
(
    input  desc_t     d,
    output pair_cat_e cat,
    output logic      is_stack,
    output logic      is_call
);

    op_e  op;
    mem_e mem;
    logic prefixed;

    assign op       = op_e'(d.op);
    assign mem      = mem_e'(d.mem);
    assign prefixed = |d.pfx;

    // Stack and call flags feed the dependency exemption.
    always_comb begin
        is_stack = (op == OP_PUSH) || (op == OP_POP);
        is_call  = (op == OP_CALL);
    end

    // Category decision; the immediate-and-displacement rule overrides everything.
    always_comb begin
        cat = CAT_NONE;
        if (d.immdisp) begin
            cat = CAT_NONE;
        end else begin
            case (op)
                OP_ALU, OP_MOV, OP_CMP, OP_TEST, OP_ADDR, OP_INCDEC:
                    cat = prefixed ? CAT_UONLY : CAT_UV;
                OP_PUSH, OP_POP:
                    if (mem != MEM_RMW) cat = prefixed ? CAT_UONLY : CAT_UV;
                    else                cat = CAT_NONE;
                OP_BRANCH:
                    cat = CAT_VONLY;
                OP_CALL:
                    cat = d.cnst ? CAT_VONLY : CAT_NONE;
                OP_SHIFT:
                    cat = d.cnst ? CAT_UONLY : CAT_NONE;
                OP_ROTATE:
                    cat = d.one ? CAT_UONLY : CAT_NONE;
                default:
                    cat = CAT_NONE;
            endcase
        end
    end

    // A prefixed instruction can never land in the either-pipe category (R4).
    always_comb begin
        if (prefixed) begin
            assert_prefix_not_uv_R4: assert (cat != CAT_UV);
        end
    end

endmodule

// File: rtl/pair_hazard.sv
// Detects the register dependency and the memory-ordering condition of a pair.
// Assumes: one source register for the younger and one destination register
// for the older are enough to describe the dependency.
module pair_hazard
    import pairing_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  desc_t            old_d,
    input  desc_t            yng_d,
    input  logic             old_stack,
    input  logic             yng_stack,
    input  logic             yng_call,
    input  logic [REG_W-1:0] old_dst,
    input  logic             old_dst_vld,
    input  logic [REG_W-1:0] yng_src,
    input  logic             yng_src_vld,
    output logic             dep_block,
    output logic             mem_wait
);

    logic reg_match;
    logic stack_exempt;

    // Raw register match between the older write and the younger read.
    always_comb begin
        reg_match = old_dst_vld && yng_src_vld && (old_dst == yng_src);
    end

    // Stack-pointer bypass: push/pop followed by push, pop or call.
    always_comb begin
        stack_exempt = old_stack && (yng_stack || yng_call);
        dep_block    = reg_match && !stack_exempt;
    end

    // Older read-modify-write with a younger load must wait for the store.
    always_comb begin
        mem_wait = (mem_e'(old_d.mem) == MEM_RMW) &&
                   ((mem_e'(yng_d.mem) == MEM_LOAD) || (mem_e'(yng_d.mem) == MEM_RMW));
    end

endmodule

// File: rtl/pair_issue_ctl.sv
// Registers the issue decision and runs the memory-ordering hold window.
// Assumes: categories and hazards arrive combinationally in the same cycle.
module pair_issue_ctl
    import pairing_pkg::*;
#(
    parameter int RMW_CYCLES = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stall,
    input  logic      old_vld,
    input  logic      yng_vld,
    input  pair_cat_e old_cat,
    input  pair_cat_e yng_cat,
    input  logic      dep_block,
    input  logic      mem_wait,
    output logic      issue_u,
    output logic      issue_v,
    output logic [1:0] consumed,
    output logic      v_hold
);

    localparam int HOLD_CYC = RMW_CYCLES - 1;
    localparam int CNT_W    = $clog2(HOLD_CYC + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             blocked;
    logic             go;
    logic             pair;
    logic             u_capable;
    logic             v_capable;

    // Slot capability and the go / pair decisions.
    always_comb begin
        blocked   = (hold_cnt != '0);
        u_capable = (old_cat == CAT_UV) || (old_cat == CAT_UONLY);
        v_capable = (yng_cat == CAT_UV) || (yng_cat == CAT_VONLY);
        go        = old_vld && !stall && !blocked;
        pair      = go && yng_vld && u_capable && v_capable && !dep_block;
    end

    // Registered issue outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_u  <= 1'b0;
            issue_v  <= 1'b0;
            consumed <= 2'd0;
        end else begin
            issue_u  <= go;
            issue_v  <= pair;
            consumed <= go ? (pair ? 2'd2 : 2'd1) : 2'd0;
        end
    end

    // Hold counter: loaded on a waiting pair, counts down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
        end else if (blocked) begin
            hold_cnt <= hold_cnt - 1'b1;
        end else if (pair && mem_wait) begin
            hold_cnt <= CNT_W'(HOLD_CYC);
        end
    end

    assign v_hold = blocked;

    assert_lockstep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_v |-> issue_u);

    assert_count_match_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed == (issue_v ? 2'd2 : (issue_u ? 2'd1 : 2'd0))));

    assert_stall_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (consumed == 2'd0));

    assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        v_hold |=> !issue_u);

endmodule

// File: rtl/dual_issue_pairer.sv
// Top of the dual-issue pairing checker: classifies both slots, checks the
// pair hazards and registers the issue decision.
// Assumes: the descriptors are in program order, older first.
module dual_issue_pairer
    import pairing_pkg::*;
#(
    parameter int REG_W      = 3,
    parameter int RMW_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             old_vld,
    input  logic [3:0]       old_op,
    input  logic [2:0]       old_pfx,
    input  logic             old_immdisp,
    input  logic [1:0]       old_mem,
    input  logic             old_cnst,
    input  logic             old_one,
    input  logic [REG_W-1:0] old_dst,
    input  logic             old_dst_vld,
    input  logic             yng_vld,
    input  logic [3:0]       yng_op,
    input  logic [2:0]       yng_pfx,
    input  logic             yng_immdisp,
    input  logic [1:0]       yng_mem,
    input  logic             yng_cnst,
    input  logic             yng_one,
    input  logic [REG_W-1:0] yng_src,
    input  logic             yng_src_vld,
    output logic             issue_u,
    output logic             issue_v,
    output logic [1:0]       consumed,
    output logic             v_hold
);

    localparam int SLOTS = 2;

    desc_t     slot_d     [SLOTS];
    pair_cat_e slot_cat   [SLOTS];
    logic      slot_stack [SLOTS];
    logic      slot_call  [SLOTS];
    logic      dep_block;
    logic      mem_wait;

    // Pack the port fields into per-slot descriptors (slot 0 is older).
    always_comb begin
        slot_d[0] = '{op: old_op, pfx: old_pfx, immdisp: old_immdisp,
                      mem: old_mem, cnst: old_cnst, one: old_one};
        slot_d[1] = '{op: yng_op, pfx: yng_pfx, immdisp: yng_immdisp,
                      mem: yng_mem, cnst: yng_cnst, one: yng_one};
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        pair_classifier u_cls (
            .d        (slot_d[s]),
            .cat      (slot_cat[s]),
            .is_stack (slot_stack[s]),
            .is_call  (slot_call[s])
        );
    end

    pair_hazard #(.REG_W(REG_W)) u_haz (
        .old_d       (slot_d[0]),
        .yng_d       (slot_d[1]),
        .old_stack   (slot_stack[0]),
        .yng_stack   (slot_stack[1]),
        .yng_call    (slot_call[1]),
        .old_dst     (old_dst),
        .old_dst_vld (old_dst_vld),
        .yng_src     (yng_src),
        .yng_src_vld (yng_src_vld),
        .dep_block   (dep_block),
        .mem_wait    (mem_wait)
    );

    pair_issue_ctl #(.RMW_CYCLES(RMW_CYCLES)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .old_vld   (old_vld),
        .yng_vld   (yng_vld),
        .old_cat   (slot_cat[0]),
        .yng_cat   (slot_cat[1]),
        .dep_block (dep_block),
        .mem_wait  (mem_wait),
        .issue_u   (issue_u),
        .issue_v   (issue_v),
        .consumed  (consumed),
        .v_hold    (v_hold)
    );

    assert_immdisp_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (old_immdisp || yng_immdisp) |=> !issue_v);

    assert_dep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (old_dst_vld && yng_src_vld && (old_dst == yng_src) &&
         !(old_op == 4'd6 || old_op == 4'd7)) |=> !issue_v);

    assert_old_invalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !old_vld |=> !issue_u);

endmodule

// File: tb/sim_dual_issue_pairer.sv
`timescale 1ns/1ps
module sim_dual_issue_pairer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0;
    logic       old_vld = 1'b0, yng_vld = 1'b0;
    logic [3:0] old_op = '0, yng_op = '0;
    logic [2:0] old_pfx = '0, yng_pfx = '0;
    logic       old_immdisp = 1'b0, yng_immdisp = 1'b0;
    logic [1:0] old_mem = '0, yng_mem = '0;
    logic       old_cnst = 1'b0, yng_cnst = 1'b0;
    logic       old_one = 1'b0, yng_one = 1'b0;
    logic [2:0] old_dst = '0, yng_src = '0;
    logic       old_dst_vld = 1'b0, yng_src_vld = 1'b0;
    logic       issue_u, issue_v, v_hold;
    logic [1:0] consumed;

    int n_checks = 0;
    int n_fail   = 0;
    int m_cnt    = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    dual_issue_pairer u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .old_vld(old_vld), .old_op(old_op), .old_pfx(old_pfx),
        .old_immdisp(old_immdisp), .old_mem(old_mem), .old_cnst(old_cnst),
        .old_one(old_one), .old_dst(old_dst), .old_dst_vld(old_dst_vld),
        .yng_vld(yng_vld), .yng_op(yng_op), .yng_pfx(yng_pfx),
        .yng_immdisp(yng_immdisp), .yng_mem(yng_mem), .yng_cnst(yng_cnst),
        .yng_one(yng_one), .yng_src(yng_src), .yng_src_vld(yng_src_vld),
        .issue_u(issue_u), .issue_v(issue_v), .consumed(consumed), .v_hold(v_hold)
    );

    // Category from the requirements: 0 either, 1 U only, 2 V only, 3 none.
    function automatic int f_cat(int op, int pfx, bit imm, int mem, bit c, bit o);
        if (imm) return 3;
        if (op <= 5 || ((op == 6 || op == 7) && mem != 3)) return (pfx != 0) ? 1 : 0;
        if (op == 8) return 2;
        if (op == 9 && c) return 2;
        if (op == 10 && c) return 1;
        if (op == 11 && o) return 1;
        return 3;
    endfunction

    task automatic set_old(int op, int pfx, bit imm, int mem, bit c, bit o, int dst, bit dv);
        old_vld = 1; old_op = 4'(op); old_pfx = 3'(pfx); old_immdisp = imm;
        old_mem = 2'(mem); old_cnst = c; old_one = o; old_dst = 3'(dst); old_dst_vld = dv;
    endtask

    task automatic set_yng(int op, int pfx, bit imm, int mem, bit c, bit o, int src, bit sv);
        yng_vld = 1; yng_op = 4'(op); yng_pfx = 3'(pfx); yng_immdisp = imm;
        yng_mem = 2'(mem); yng_cnst = c; yng_one = o; yng_src = 3'(src); yng_src_vld = sv;
    endtask

    // One cycle: compute the expectation, clock, then compare away from the edge.
    task automatic step(string tag);
        bit eu, ev, eh;
        int ec, oc, yc, ncnt;
        bit blocked, go, pr, dep, exm, mw;
        oc = f_cat(old_op, old_pfx, old_immdisp, old_mem, old_cnst, old_one);
        yc = f_cat(yng_op, yng_pfx, yng_immdisp, yng_mem, yng_cnst, yng_one);
        blocked = (m_cnt != 0);
        go  = old_vld && !stall && !blocked;
        exm = (old_op == 6 || old_op == 7) && (yng_op == 6 || yng_op == 7 || yng_op == 9);
        dep = old_dst_vld && yng_src_vld && (old_dst == yng_src) && !exm;
        mw  = (old_mem == 3) && (yng_mem == 1 || yng_mem == 3);
        pr  = go && yng_vld && (oc == 0 || oc == 1) && (yc == 0 || yc == 2) && !dep;
        if (!rst_n)        ncnt = 0;
        else if (blocked)  ncnt = m_cnt - 1;
        else if (pr && mw) ncnt = 2;
        else               ncnt = 0;
        eu = rst_n && go;
        ev = rst_n && pr;
        ec = eu ? (ev ? 2 : 1) : 0;
        eh = (ncnt != 0);
        @(posedge clk);
        m_cnt = ncnt;
        @(negedge clk);
        n_checks++;
        if (issue_u !== eu || issue_v !== ev || consumed !== 2'(ec) || v_hold !== eh) begin
            n_fail++;
            $display("FAIL %s: u/v/cnt/hold got %0b/%0b/%0d/%0b expected %0b/%0b/%0d/%0b",
                     tag, issue_u, issue_v, consumed, v_hold, eu, ev, ec, eh);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        step("R1"); step("R1");
        set_old(0,0,0,0,0,0,0,0); set_yng(1,0,0,0,0,0,1,0);
        step("R1");
        rst_n = 1;
        // R3 / R13: plain either-pipe pair
        step("R3");
        set_old(6,0,0,2,0,0,4,1); set_yng(7,0,0,1,0,0,2,1);
        step("R3");
        set_old(6,0,0,3,0,0,4,0); step("R3");
        // R2: immediate and displacement in each slot
        set_old(0,0,1,0,0,0,0,0); set_yng(1,0,0,0,0,0,0,0); step("R2");
        set_old(0,0,0,0,0,0,0,0); set_yng(1,0,1,0,0,0,0,0); step("R2");
        // R4: prefix demotion
        set_old(0,3'b100,0,0,0,0,0,0); set_yng(2,0,0,0,0,0,0,0); step("R4");
        set_old(0,0,0,0,0,0,0,0); set_yng(2,3'b001,0,0,0,0,0,0); step("R4");
        // R5: V-only branch and constant call
        set_yng(8,0,0,0,0,0,0,0); step("R5");
        set_old(8,0,0,0,0,0,0,0); set_yng(0,0,0,0,0,0,0,0); step("R5");
        set_old(0,0,0,0,0,0,0,0); set_yng(9,0,0,0,1,0,0,0); step("R5");
        set_yng(9,0,0,0,0,0,0,0); step("R5");
        // R6: shift and rotate
        set_old(10,0,0,0,1,0,0,0); set_yng(0,0,0,0,0,0,0,0); step("R6");
        set_old(0,0,0,0,0,0,0,0); set_yng(10,0,0,0,1,0,0,0); step("R6");
        set_old(10,0,0,0,0,0,0,0); set_yng(0,0,0,0,0,0,0,0); step("R6");
        set_old(11,0,0,0,0,1,0,0); step("R6");
        set_old(11,0,0,0,1,0,0,0); step("R6");
        // R7: not pairable in each slot
        set_old(12,0,0,0,0,0,0,0); set_yng(0,0,0,0,0,0,0,0); step("R7");
        set_old(0,0,0,0,0,0,0,0); set_yng(13,0,0,0,0,0,0,0); step("R7");
        // R9: register dependency
        set_old(0,0,0,0,0,0,3,1); set_yng(0,0,0,0,0,0,3,1); step("R9");
        set_yng(0,0,0,0,0,0,4,1); step("R9");
        // R10: stack exemption
        set_old(6,0,0,2,0,0,4,1); set_yng(6,0,0,2,0,0,4,1); step("R10");
        set_yng(9,0,0,0,1,0,4,1); step("R10");
        set_old(0,0,0,0,0,0,4,1); set_yng(6,0,0,2,0,0,4,1); step("R10");
        // R11: memory-ordering hold window
        set_old(0,0,0,3,0,0,0,0); set_yng(1,0,0,1,0,0,1,0); step("R11");
        set_old(0,0,0,0,0,0,0,0); set_yng(1,0,0,0,0,0,1,0); step("R11");
        step("R11"); step("R11");
        // R12: stall and valid gaps
        stall = 1; step("R12"); stall = 0;
        old_vld = 0; step("R12"); old_vld = 1;
        yng_vld = 0; step("R12"); yng_vld = 1;
        // R13: seeded random mix
        for (int i = 0; i < 4000; i++) begin
            set_old($urandom % 16, (($urandom % 4) == 0) ? ($urandom % 8) : 0,
                    ($urandom % 8) == 0, $urandom % 4, $urandom % 2, $urandom % 2,
                    $urandom % 8, $urandom % 2);
            set_yng($urandom % 16, (($urandom % 4) == 0) ? ($urandom % 8) : 0,
                    ($urandom % 8) == 0, $urandom % 4, $urandom % 2, $urandom % 2,
                    $urandom % 8, $urandom % 2);
            old_vld = ($urandom % 10) != 0;
            yng_vld = ($urandom % 10) != 0;
            stall   = ($urandom % 10) == 0;
            step("R13");
        end
        stall = 0;
        // R1: reset in the middle of a hold window
        set_old(0,0,0,3,0,0,0,0); set_yng(1,0,0,3,0,0,1,0); step("R11");
        rst_n = 0; step("R1"); rst_n = 1; step("R1");
        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule